// File: doc/BRIEF.md
# IR Mark and Symbol Period Capture Receiver

This block watches a demodulated remote-control input, either infrared or UHF, and times every symbol on a sampling tick. The tick is the system clock divided by a programmable integer. For each symbol it records two counts: how long the carrier was present (the mark), and the full symbol period from the start of that mark to the start of the next one. Software works out the space as the period minus the mark. The pairs queue in a small receive FIFO. Software drains the FIFO through a simple word-addressed register port.

A train ends when the space after a mark runs on until the period count reaches a programmed limit. The last entry then carries the reserved period code 0xFFFF. The status bits for received data, last symbol, overrun and FIFO full are sticky and cleared by write-one-to-clear. The interrupt line merges them under per-source enables.

Top module: `ir_capture_rx`

## Requirements
- R1: After reset, the registers CTRL (0), DIV (1), MAXP (2), IEN (3), ISTAT (4) and RXSTAT (6) read 0, the FIFO is empty and `irq` is low.
- R2: With capture on, each symbol produces one entry. The mark count is the number of ticks on which the input was active. The period count is the number of ticks from the first active tick of the mark to the first active tick of the next mark. The entry is pushed when that next mark begins.
- R3: If, during a space, the period count reaches the value in MAXP, the entry {mark, 0xFFFF} is pushed, the train ends, and ISTAT bit 1 (last symbol) is set.
- R4: A tick occurs every DIV clocks, and DIV = 0 acts as 1. All counts are in ticks.
- R5: With CTRL bit 1 = 0 a high input is active. With CTRL bit 1 = 1 a low input is active.
- R6: While CTRL bit 0 = 0, nothing is captured and no entry or status results.
- R7: The FIFO holds 8 entries, oldest first. Reading PERIOD (7) returns the head period without removing it. Reading MARK (8) returns the head mark and removes the entry.
- R8: A push into a full FIFO drops the entry and sets ISTAT bit 2 (overrun). Each accepted push sets ISTAT bit 0. A push that fills the FIFO sets ISTAT bit 3.
- R9: RXSTAT reads 0xFF in bits 15:8 when the FIFO is non-empty, with 0 there otherwise. Bit 2 mirrors the overrun status.
- R10: Writing ICLR (5) clears each ISTAT bit written as 1, and writing 0x0F clears all four bits. The status bits stay set until cleared.
- R11: `irq` is high exactly when some ISTAT bit and the matching IEN bit are both 1.
- R12: The mark and period counters saturate at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_in | input | 1 | Demodulated remote-control input, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of MARK pops the FIFO |
| reg_addr | input | 4 | Word address of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, valid in the same cycle |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 16-bit counters and an 8-entry FIFO. At a divisor of 0 or 1 every clock is a tick, so the counts can be predicted exactly from clock cycles. A divisor of 4 shows that counts scale to ticks. The 16-bit counters make saturation reachable with a mark of about 70,000 cycles. The 8-deep FIFO lets nine back-to-back symbols drive it into overrun.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
    localparam int SYM_W = 16;

    typedef struct packed {
        logic [SYM_W-1:0] mark;
        logic [SYM_W-1:0] period;
    } ir_sym_t;

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_DIV    = 4'd1;
    localparam logic [3:0] A_MAXP   = 4'd2;
    localparam logic [3:0] A_IEN    = 4'd3;
    localparam logic [3:0] A_ISTAT  = 4'd4;
    localparam logic [3:0] A_ICLR   = 4'd5;
    localparam logic [3:0] A_RXSTAT = 4'd6;
    localparam logic [3:0] A_PERIOD = 4'd7;
    localparam logic [3:0] A_MARK   = 4'd8;

    localparam int ST_DATA = 0;
    localparam int ST_LAST = 1;
    localparam int ST_OVR  = 2;
    localparam int ST_FULL = 3;
endpackage

// File: rtl/ir_in_sync.sv
module ir_in_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic invert_i,
    output logic active_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = pin_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign active_o = q.s2 ^ invert_i;
endmodule

// File: rtl/ir_tick_div.sv
module ir_tick_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_t;

    div_t q, d;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim = (div_i == '0) ? '0 : div_i - DIV_W'(1);
        d   = q;
        if (!enable_i) begin
            d.cnt  = '0;
            d.tick = 1'b0;
        end else begin
            d.tick = (q.cnt >= lim);
            d.cnt  = (q.cnt >= lim) ? '0 : q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign tick_o = q.tick;

    // R4: with a stable divisor above 1, ticks never fall on adjacent clocks
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (q.tick && div_i > DIV_W'(1)) |=> (!q.tick || !$stable(div_i)));
endmodule

// File: rtl/ir_symbol_meter.sv
module ir_symbol_meter
    import ir_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic [SYM_W-1:0] max_per_i,
    output logic             push_o,
    output ir_sym_t          sym_o
);
    typedef enum logic [1:0] {S_IDLE, S_MARK, S_SPACE} mstate_e;

    typedef struct packed {
        mstate_e          state;
        logic [SYM_W-1:0] mark;
        logic [SYM_W-1:0] per;
        logic             push;
        ir_sym_t          sym;
    } meter_t;

    localparam logic [SYM_W-1:0] ALL1 = '1;

    meter_t q, d;

    function automatic logic [SYM_W-1:0] inc_sat(input logic [SYM_W-1:0] v);
        return (v == ALL1) ? v : v + SYM_W'(1);
    endfunction

    always_comb begin
        d      = q;
        d.push = 1'b0;
        if (!enable_i) begin
            d.state = S_IDLE;
            d.mark  = '0;
            d.per   = '0;
        end else if (tick_i) begin
            unique case (q.state)
                S_IDLE: if (active_i) begin
                    d.state = S_MARK;
                    d.mark  = SYM_W'(1);
                    d.per   = SYM_W'(1);
                end
                S_MARK: begin
                    d.per = inc_sat(q.per);
                    if (active_i) d.mark  = inc_sat(q.mark);
                    else          d.state = S_SPACE;
                end
                S_SPACE: begin
                    if (active_i) begin
                        d.push  = 1'b1;
                        d.sym   = '{mark: q.mark, period: q.per};
                        d.mark  = SYM_W'(1);
                        d.per   = SYM_W'(1);
                        d.state = S_MARK;
                    end else if (q.per >= max_per_i) begin
                        d.push  = 1'b1;
                        d.sym   = '{mark: q.mark, period: ALL1};
                        d.state = S_IDLE;
                    end else begin
                        d.per = inc_sat(q.per);
                    end
                end
                default: d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign push_o = q.push;
    assign sym_o  = q.sym;

    // R6: no entry leaves the meter once capture has been off for a cycle
    p_no_push_off_r6: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> !push_o);
    // R12: counters hold at all-ones rather than wrapping
    p_mark_sat_r12: assert property (@(posedge clk) disable iff (rst)
        (enable_i && q.mark == ALL1 && q.state == S_MARK) |=> (q.mark != '0));
    p_per_sat_r12: assert property (@(posedge clk) disable iff (rst)
        (enable_i && q.per == ALL1 && q.state != S_IDLE) |=> (q.per != '0));
endmodule

// File: rtl/ir_sym_fifo.sv
module ir_sym_fifo
    import ir_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push_i,
    input  ir_sym_t data_i,
    input  logic    pop_i,
    output ir_sym_t head_o,
    output logic    empty_o,
    output logic    accept_o,
    output logic    fills_o,
    output logic    drop_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t   q, d;
    ir_sym_t mem [DEPTH];
    logic    do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d        = q;
        accept_o = push_i && (q.cnt != CW'(DEPTH));
        drop_o   = push_i && (q.cnt == CW'(DEPTH));
        fills_o  = accept_o && !do_pop && (q.cnt == CW'(DEPTH - 1));
        if (accept_o) d.wp = nxt(q.wp);
        if (do_pop)   d.rp = nxt(q.rp);
        if (accept_o && !do_pop)      d.cnt = q.cnt + CW'(1);
        else if (!accept_o && do_pop) d.cnt = q.cnt - CW'(1);
    end

    assign do_pop  = pop_i && (q.cnt != '0);
    assign empty_o = (q.cnt == '0);
    assign head_o  = mem[q.rp];

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    always_ff @(posedge clk) begin
        if (accept_o) mem[q.wp] <= data_i;
    end

    // R7: occupancy never exceeds the depth
    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        q.cnt <= CW'(DEPTH));
    // R8: a push into a full FIFO without a pop leaves it unchanged
    p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (push_i && q.cnt == CW'(DEPTH) && !pop_i) |=> (q.cnt == CW'(DEPTH) && $stable(q.wp)));
endmodule

// File: rtl/ir_capture_rx.sv
module ir_capture_rx
    import ir_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ir_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    typedef struct packed {
        logic             en;
        logic             inv;
        logic [SYM_W-1:0] div;
        logic [SYM_W-1:0] maxp;
        logic [3:0]       ien;
        logic [3:0]       stat;
    } regs_t;

    regs_t   r_q, r_d;
    logic    active, tick, m_push, f_empty, f_accept, f_fills, f_drop, pop;
    ir_sym_t m_sym, head;
    logic [3:0] set_bits, clr_bits;

    ir_in_sync u_sync (
        .clk(clk), .rst(rst), .pin_i(ir_in), .invert_i(r_q.inv), .active_o(active)
    );

    ir_tick_div #(.DIV_W(SYM_W)) u_div (
        .clk(clk), .rst(rst), .enable_i(r_q.en), .div_i(r_q.div), .tick_o(tick)
    );

    ir_symbol_meter u_meter (
        .clk(clk), .rst(rst), .enable_i(r_q.en), .tick_i(tick), .active_i(active),
        .max_per_i(r_q.maxp), .push_o(m_push), .sym_o(m_sym)
    );

    ir_sym_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push_i(m_push), .data_i(m_sym), .pop_i(pop),
        .head_o(head), .empty_o(f_empty), .accept_o(f_accept), .fills_o(f_fills),
        .drop_o(f_drop)
    );

    assign pop = reg_rd && (reg_addr == A_MARK);

    always_comb begin
        set_bits          = '0;
        set_bits[ST_DATA] = f_accept;
        set_bits[ST_LAST] = f_accept && (m_sym.period == '1);
        set_bits[ST_OVR]  = f_drop;
        set_bits[ST_FULL] = f_fills;
        clr_bits = (reg_wr && reg_addr == A_ICLR) ? reg_wdata[3:0] : 4'h0;

        r_d      = r_q;
        r_d.stat = (r_q.stat & ~clr_bits) | set_bits;
        if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL: begin
                    r_d.en  = reg_wdata[0];
                    r_d.inv = reg_wdata[1];
                end
                A_DIV:   r_d.div  = reg_wdata;
                A_MAXP:  r_d.maxp = reg_wdata;
                A_IEN:   r_d.ien  = reg_wdata[3:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:   reg_rdata = {14'h0, r_q.inv, r_q.en};
            A_DIV:    reg_rdata = r_q.div;
            A_MAXP:   reg_rdata = r_q.maxp;
            A_IEN:    reg_rdata = {12'h0, r_q.ien};
            A_ISTAT:  reg_rdata = {12'h0, r_q.stat};
            A_RXSTAT: reg_rdata = {f_empty ? 8'h00 : 8'hFF, 5'h0, r_q.stat[ST_OVR], 2'b00};
            A_PERIOD: reg_rdata = head.period;
            A_MARK:   reg_rdata = head.mark;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(r_q.stat & r_q.ien);

    // R8: a dropped entry raises overrun on the next cycle
    p_drop_flags_r8: assert property (@(posedge clk) disable iff (rst)
        f_drop |=> r_q.stat[ST_OVR]);
    // R10: overrun stays set until a write-one-to-clear of bit 2
    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (r_q.stat[ST_OVR] && !(reg_wr && reg_addr == A_ICLR && reg_wdata[ST_OVR]))
        |=> r_q.stat[ST_OVR]);
    // R11: with all enables cleared the line stays low
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
        (r_q.ien == 4'h0) |-> !irq);
endmodule

// File: tb/tb_ir_capture_rx.sv
module tb_ir_capture_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ir_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic act_lvl = 1'b1;

    always #2.5 clk = ~clk;

    ir_capture_rx dut (
        .clk(clk), .rst(rst), .ir_in(ir_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic do_reset(input logic idle_lvl);
        @(negedge clk);
        ir_in = idle_lvl; rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic sym(input int m, input int s);
        ir_in = act_lvl;
        repeat (m) @(negedge clk);
        ir_in = ~act_lvl;
        repeat (s) @(negedge clk);
    endtask

    task automatic start_mark();
        ir_in = act_lvl;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        rd_chk("R1 ctrl", 4'd0, 16'h0);
        rd_chk("R1 div", 4'd1, 16'h0);
        rd_chk("R1 maxp", 4'd2, 16'h0);
        rd_chk("R1 ien", 4'd3, 16'h0);
        rd_chk("R1 istat", 4'd4, 16'h0);
        rd_chk("R1 rxstat", 4'd6, 16'h0);
        chk("R1 irq", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_basic();
        do_reset(1'b0); act_lvl = 1'b1;
        wr(4'd2, 16'd1000);
        wr(4'd0, 16'h1);
        sym(10, 15); sym(20, 5); start_mark();
        rd_chk("R9 rxstat nonempty", 4'd6, 16'hFF00);
        rd_chk("R2 period0", 4'd7, 16'd25);
        rd_chk("R7 peek keeps head", 4'd7, 16'd25);
        rd_chk("R2 mark0", 4'd8, 16'd10);
        rd_chk("R2 period1", 4'd7, 16'd25);
        rd_chk("R2 mark1", 4'd8, 16'd20);
        rd_chk("R9 rxstat empty", 4'd6, 16'h0000);
        rd_chk("R8 data status", 4'd4, 16'h0001);
    endtask

    task automatic t_timeout();
        do_reset(1'b0); act_lvl = 1'b1;
        wr(4'd2, 16'd100);
        wr(4'd0, 16'h1);
        sym(10, 200);
        rd_chk("R3 period code", 4'd7, 16'hFFFF);
        rd_chk("R3 mark", 4'd8, 16'd10);
        rd_chk("R3 last status", 4'd4, 16'h0003);
    endtask

    task automatic t_div();
        do_reset(1'b0); act_lvl = 1'b1;
        wr(4'd1, 16'd4);
        wr(4'd2, 16'd1000);
        wr(4'd0, 16'h1);
        sym(40, 40); start_mark();
        rd_chk("R4 period ticks", 4'd7, 16'd20);
        rd_chk("R4 mark ticks", 4'd8, 16'd10);
    endtask

    task automatic t_polarity();
        do_reset(1'b1); act_lvl = 1'b0;
        wr(4'd2, 16'd1000);
        wr(4'd0, 16'h3);
        repeat (4) @(negedge clk);
        sym(12, 8); start_mark();
        rd_chk("R5 inverted period", 4'd7, 16'd20);
        rd_chk("R5 inverted mark", 4'd8, 16'd12);
        act_lvl = 1'b1;
    endtask

    task automatic t_disabled();
        do_reset(1'b0); act_lvl = 1'b1;
        wr(4'd2, 16'd1000);
        sym(10, 10); sym(10, 10); start_mark();
        ir_in = 1'b0;
        repeat (20) @(negedge clk);
        rd_chk("R6 no entry", 4'd6, 16'h0000);
        rd_chk("R6 no status", 4'd4, 16'h0000);
    endtask

    task automatic t_overrun_clear_irq();
        do_reset(1'b0); act_lvl = 1'b1;
        wr(4'd2, 16'd1000);
        wr(4'd0, 16'h1);
        for (int i = 0; i < 9; i++) sym(3, 4);
        start_mark();
        rd_chk("R8 overrun+full status", 4'd4, 16'h000D);
        rd_chk("R9 rxstat overflow", 4'd6, 16'hFF04);
        chk("R11 irq masked", {15'h0, irq}, 16'h0);
        for (int i = 0; i < 8; i++) begin
            rd_chk("R7 entry period", 4'd7, 16'd7);
            rd_chk("R7 entry mark", 4'd8, 16'd3);
        end
        rd_chk("R8 ninth dropped", 4'd6, 16'h0004);
        wr(4'd3, 16'h1);
        @(negedge clk);
        chk("R11 irq data enabled", {15'h0, irq}, 16'h1);
        wr(4'd3, 16'h2);
        @(negedge clk);
        chk("R11 irq last disabled source", {15'h0, irq}, 16'h0);
        wr(4'd5, 16'h4);
        rd_chk("R10 clear overrun only", 4'd4, 16'h0009);
        wr(4'd3, 16'hF);
        @(negedge clk);
        chk("R11 irq all enabled", {15'h0, irq}, 16'h1);
        wr(4'd5, 16'hF);
        rd_chk("R10 clear all", 4'd4, 16'h0000);
        chk("R11 irq after clear", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_saturate();
        do_reset(1'b0); act_lvl = 1'b1;
        wr(4'd2, 16'd100);
        wr(4'd0, 16'h1);
        sym(70000, 20);
        rd_chk("R12 period saturated", 4'd7, 16'hFFFF);
        rd_chk("R12 mark saturated", 4'd8, 16'hFFFF);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_timeout();
        t_div();
        t_polarity();
        t_disabled();
        t_overrun_clear_irq();
        t_saturate();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule